// File: doc/BRIEF.md
# Interleaved Memory Bank Scheduler

This block takes one stream of word-aligned memory requests and sends each one to one of several word-interleaved banks. The bank is picked from the low bits of the word address, so neighbouring words go to neighbouring banks. A bank that accepts a request stays occupied for a fixed number of cycles, and the accept cycle counts as the first of them. Requests leave strictly in order. When the request at the head of the stream targets an occupied bank, the whole stream waits. It does not skip ahead to a later request. Each such wait is counted once as a bank conflict.

Four running totals are kept and made visible: completed accesses, bytes moved, active cycles and conflicts. Bandwidth follows as bytes divided by active cycles. Reads and writes are scheduled the same way. The direction bit only travels with the dispatched request.

Top module: `ilvb_sched`

## Requirements
- R1: The target bank equals the word index (byte address shifted right by 2) modulo NUM_BANKS. With 4 banks this is address bits [3:2]. Address bits [1:0] have no effect. The bank of an accepted request appears on `issue_bank`.
- R2: A request is accepted in a cycle exactly when `req_valid` is high and `req_ready` is high. `issue_valid` is high in that same cycle. At most one request is accepted per cycle.
- R3: An accepted request occupies its bank for ACCESS_CYCLES cycles (default 8), counting the accept cycle. A request to the same bank is accepted no earlier than ACCESS_CYCLES cycles later. Requests to different idle banks are accepted in consecutive cycles.
- R4: `req_ready` is low whenever the bank targeted by `req_addr` is occupied, so the head request is held and no later request passes it.
- R5: `conflict_count` rises by exactly 1 for each request that finds its bank occupied, however many cycles it waits.
- R6: After reset all counters read 0 and `req_ready` is high. The first request after reset is never counted as a conflict.
- R7: `byte_count` rises by 4 in the cycle after each acceptance and is unchanged otherwise.
- R8: `done_count` rises by 1 for every finished access. The increase is visible ACCESS_CYCLES cycles after the accept cycle.
- R9: `cycle_count` rises by 1 after every cycle in which `req_valid` is high or any bank is occupied. It holds during fully idle cycles.
- R10: The value of `req_write` changes no timing and no count. It is copied to `issue_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head request present |
| req_addr | input | ADDR_W | Byte address of the head request |
| req_write | input | 1 | Direction of the head request (1 = write) |
| req_ready | output | 1 | Target bank of the head request is free |
| issue_valid | output | 1 | A request is dispatched this cycle |
| issue_bank | output | BANK_W | Bank receiving the dispatched request |
| issue_write | output | 1 | Direction of the dispatched request |
| done_count | output | CNT_W | Finished accesses |
| cycle_count | output | CNT_W | Active cycles |
| conflict_count | output | CNT_W | Bank conflicts |
| byte_count | output | CNT_W | Bytes transferred |

## Verification
Two events can land in the same cycle. One is a stalled request being accepted. The other is the finish of the access that blocked it, which raises `done_count`.

Back-to-back requests to one bank provoke this. So do sequences of five consecutive words that wrap onto bank 0. Random traffic over a small address range provokes it as well.

A bench model predicts the cycle at which each bank frees up. Every cycle it compares `req_ready`, the dispatch outputs and all four counters against that model. This confirms that the release and the completion both take effect, that neither is lost, and that the conflict is not counted a second time.

// File: rtl/ilvb_pkg.sv
package ilvb_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_SHIFT = 2;

  // bank index for a word index under word interleaving
  function automatic int unsigned pick_bank(input logic [31:0] word_idx,
                                            input int unsigned nbanks);
    return word_idx % nbanks;
  endfunction

  function automatic int unsigned bank_width(input int unsigned nbanks);
    return (nbanks > 1) ? $clog2(nbanks) : 1;
  endfunction
endpackage

// File: rtl/ilvb_bank_timer.sv
module ilvb_bank_timer #(
  parameter int ACCESS_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish
);
  generate
    if (ACCESS_CYCLES <= 1) begin : g_single
      assign busy   = 1'b0;
      assign finish = start;
    end else begin : g_multi
      localparam int CW = $clog2(ACCESS_CYCLES);
      logic [CW-1:0] remain;
      always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= CW'(ACCESS_CYCLES - 1);
        else if (remain != '0)   remain <= remain - 1'b1;
      end
      assign busy   = (remain != '0);
      assign finish = (remain == CW'(1));
    end
  endgenerate
endmodule

// File: rtl/ilvb_stall_track.sv
module ilvb_stall_track (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic ready,
  output logic conflict_evt
);
  logic waiting_q;
  logic waiting;
  assign waiting = valid & ~ready;
  always_ff @(posedge clk) begin
    if (!rst_n) waiting_q <= 1'b0;
    else        waiting_q <= waiting;
  end
  // first stalled cycle of a request only
  assign conflict_evt = waiting & ~waiting_q;
endmodule

// File: rtl/ilvb_accum.sv
module ilvb_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] step,
  output logic [W-1:0] total
);
  always_ff @(posedge clk) begin
    if (!rst_n)  total <= '0;
    else if (en) total <= total + step;
  end
endmodule

// File: rtl/ilvb_sched.sv
module ilvb_sched #(
  parameter int NUM_BANKS     = 4,
  parameter int ACCESS_CYCLES = 8,
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 32,
  localparam int BANK_W       = ilvb_pkg::bank_width(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              req_ready,
  output logic              issue_valid,
  output logic [BANK_W-1:0] issue_bank,
  output logic              issue_write,
  output logic [CNT_W-1:0]  done_count,
  output logic [CNT_W-1:0]  cycle_count,
  output logic [CNT_W-1:0]  conflict_count,
  output logic [CNT_W-1:0]  byte_count
);
  localparam int SHIFT = ilvb_pkg::WORD_SHIFT;

  // named internal events
  logic [BANK_W-1:0]    sel;
  logic [NUM_BANKS-1:0] busy_vec;
  logic [NUM_BANKS-1:0] finish_vec;
  logic [NUM_BANKS-1:0] start_vec;
  logic                 accept;
  logic                 conflict_evt;
  logic                 active;
  logic                 finish_any;

  assign sel = BANK_W'(ilvb_pkg::pick_bank(32'(req_addr >> SHIFT), NUM_BANKS));

  assign req_ready   = ~busy_vec[sel];
  assign accept      = req_valid & req_ready;
  assign issue_valid = accept;
  assign issue_bank  = sel;
  assign issue_write = req_write;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign start_vec[b] = accept && (sel == BANK_W'(b));
      ilvb_bank_timer #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_vec[b]),
        .busy   (busy_vec[b]),
        .finish (finish_vec[b])
      );
    end
  endgenerate

  ilvb_stall_track u_stall (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (req_valid),
    .ready        (req_ready),
    .conflict_evt (conflict_evt)
  );

  assign active     = req_valid | (|busy_vec);
  assign finish_any = |finish_vec;

  ilvb_accum #(.W(CNT_W)) u_done (
    .clk(clk), .rst_n(rst_n), .en(finish_any), .step(CNT_W'(1)), .total(done_count));
  ilvb_accum #(.W(CNT_W)) u_cycles (
    .clk(clk), .rst_n(rst_n), .en(active), .step(CNT_W'(1)), .total(cycle_count));
  ilvb_accum #(.W(CNT_W)) u_conf (
    .clk(clk), .rst_n(rst_n), .en(conflict_evt), .step(CNT_W'(1)), .total(conflict_count));
  ilvb_accum #(.W(CNT_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .en(accept), .step(CNT_W'(ilvb_pkg::WORD_BYTES)),
    .total(byte_count));
endmodule

// File: rtl/ilvb_sched_chk.sv
module ilvb_sched_chk #(
  parameter int NUM_BANKS     = 4,
  parameter int ACCESS_CYCLES = 8,
  parameter int CNT_W         = 32,
  parameter int BANK_W        = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 issue_valid,
  input logic [BANK_W-1:0]    issue_bank,
  input logic [NUM_BANKS-1:0] finish_vec,
  input logic [CNT_W-1:0]     done_count,
  input logic [CNT_W-1:0]     cycle_count,
  input logic [CNT_W-1:0]     conflict_count,
  input logic [CNT_W-1:0]     byte_count
);
  // R3: a bank never takes two requests in adjacent cycles
  a_r3_same_bank_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ACCESS_CYCLES > 1 && issue_valid) |=> !(issue_valid && issue_bank == $past(issue_bank)));

  // R5: continued stall adds nothing
  a_r5_conflict_once: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && $past(req_valid && !req_ready)) |=> $stable(conflict_count));

  // R6: a request that finds its bank free is not a conflict
  a_r6_ready_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> $stable(conflict_count));

  // R7: byte steps
  a_r7_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> byte_count == $past(byte_count) + CNT_W'(4));
  a_r7_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $stable(byte_count));

  // R8: finishes never coincide and never outnumber acceptances
  a_r8_single_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(finish_vec));
  a_r8_done_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    done_count <= (byte_count >> 2));

  // R9: a pending request always advances the cycle count
  a_r9_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> cycle_count == $past(cycle_count) + CNT_W'(1));
endmodule

bind ilvb_sched ilvb_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .ACCESS_CYCLES(ACCESS_CYCLES), .CNT_W(CNT_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .issue_valid(issue_valid), .issue_bank(issue_bank), .finish_vec(finish_vec),
  .done_count(done_count), .cycle_count(cycle_count),
  .conflict_count(conflict_count), .byte_count(byte_count)
);

// File: tb/test_ilvb_sched.sv
`timescale 1ns/1ps
module test_ilvb_sched;
  localparam int NB  = 4;
  localparam int ACC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_ready, issue_valid, issue_write;
  logic [1:0]  issue_bank;
  logic [31:0] done_count, cycle_count, conflict_count, byte_count;

  always #2.5 clk = ~clk;

  ilvb_sched #(.NUM_BANKS(NB), .ACCESS_CYCLES(ACC), .ADDR_W(32), .CNT_W(32)) i_ilvb_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_ready(req_ready), .issue_valid(issue_valid),
    .issue_bank(issue_bank), .issue_write(issue_write), .done_count(done_count),
    .cycle_count(cycle_count), .conflict_count(conflict_count), .byte_count(byte_count));

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int free_at [NB];
  int pend_at [NB];
  int m_done = 0, m_cyc = 0, m_conf = 0, m_bytes = 0;
  bit m_stall = 0, last_acc = 0;

  function automatic int bank_of(input logic [31:0] a);
    return int'((a / 4) % NB);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic w);
    int  bk;
    bit  exp_rdy, any;
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = w;
    #1;
    for (int b = 0; b < NB; b++)
      if (pend_at[b] >= 0 && pend_at[b] <= cyc) begin m_done++; pend_at[b] = -1; end
    bk = bank_of(a);
    exp_rdy = (cyc >= free_at[bk]);
    chk("R4 ready", req_ready, exp_rdy);
    chk("R2 issue_valid", issue_valid, v && exp_rdy);
    if (v && exp_rdy) begin
      chk("R1 issue_bank", issue_bank, bk);
      chk("R10 issue_write", issue_write, w);
    end
    chk("R5 conflict_count", conflict_count, m_conf);
    chk("R7 byte_count", byte_count, m_bytes);
    chk("R8 done_count", done_count, m_done);
    chk("R9 cycle_count", cycle_count, m_cyc);
    any = v;
    for (int b = 0; b < NB; b++) if (cyc < free_at[b]) any = 1;
    if (any) m_cyc++;
    if (v && !exp_rdy && !m_stall) m_conf++;
    m_stall = v && !exp_rdy;
    last_acc = v && exp_rdy;
    if (last_acc) begin
      free_at[bk] = cyc + ACC; pend_at[bk] = cyc + ACC; m_bytes += 4;
    end
    cyc++;
  endtask

  task automatic send(input logic [31:0] a, input logic w, output int stalls);
    stalls = 0;
    step(1'b1, a, w);
    while (!last_acc) begin stalls++; step(1'b1, a, w); end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 1'b0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int st, c0;
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin free_at[b] = 0; pend_at[b] = -1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R6: reset state
    chk("R6 reset done", done_count, 0);
    chk("R6 reset cycles", cycle_count, 0);
    chk("R6 reset conflicts", conflict_count, 0);
    chk("R6 reset bytes", byte_count, 0);
    chk("R6 reset ready", req_ready, 1);

    // R6: first request never conflicts
    send(32'h0, 1'b0, st);
    chk("R6 first stalls", st, 0);
    idle(1);
    chk("R6 first conflict", conflict_count, 0);
    idle(ACC + 2);

    // R3: consecutive words on distinct banks, fifth wraps to bank 0
    send(32'h0, 1'b0, st); chk("R3 bank0 stalls", st, 0);
    send(32'h4, 1'b1, st); chk("R3 bank1 stalls", st, 0);
    send(32'h8, 1'b0, st); chk("R3 bank2 stalls", st, 0);
    send(32'hC, 1'b1, st); chk("R3 bank3 stalls", st, 0);
    c0 = m_conf;
    send(32'h10, 1'b0, st); chk("R3 wrap stalls", st, ACC - NB);
    idle(1);
    chk("R5 single conflict", conflict_count, c0 + 1);
    idle(ACC + 2);

    // R1/R3: same bank back to back, low address bits set
    send(32'h23, 1'b1, st);
    send(32'h41, 1'b0, st); chk("R3 same bank stalls", st, ACC - 1);
    idle(ACC + 3);

    // R9: fully idle stretch keeps cycle_count stable
    c0 = m_cyc;
    idle(5);
    chk("R9 idle hold", cycle_count, c0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
      else send({26'($urandom % 16), 4'h0, 2'($urandom)} >> 4 << 0 | ((($urandom % 16) << 2) | ($urandom % 4)),
                1'($urandom), st);
    end
    idle(ACC + 2);
    chk("R8 final done", done_count, m_bytes / 4);

    summary();
    $finish;
  end
endmodule